// File: doc/BRIEF.md
# Synchronized-Fire Cell Chain

A linear chain of `N` identical cells shares one clock. No other signal is common to the cells. Each cell updates its state from three things only: its own phase, the phase of the cell to its left and the phase of the cell to its right. The missing neighbour at each end of the chain is modelled as a fixed border phase. The left border changes to a "go" phase while `start` is high. That is how a start request enters the chain, through the normal neighbour path.

After a start, a marker wave travels from the left end to the right end and reflects back. While it is out, each cell counts the cycles until the wave returns, so every cell learns twice its distance from the right end. When the wave reaches the left end, a second wave leaves it. As that wave passes, each cell counts down half of its stored value. The schedule is arranged so that every cell reaches its terminal firing phase on the same edge, 3N-2 cycles after the edge that sampled `start`.

Once a run has begun, further start requests find the leftmost cell busy and have no effect. Firing is terminal until reset.

Top module: `fire_chain`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `fire` is all zeros.
- R2: Without a start request, no cell ever leaves its quiet state and `fire` stays all zeros, for any number of cycles.
- R3: The `fire` vector only ever holds all zeros or all ones. No cycle shows a subset of the cells firing.
- R4: `fire` becomes all ones exactly 3N-2 clock cycles after the rising clock edge that first samples `start` high. This is never more than 3N cycles.
- R5: Once `fire` is all ones, it stays all ones until `rstN` is asserted.
- R6: A `start` level that is held high, or pulsed again while a run is in progress, does not change the firing cycle set by the first sampled edge.
- R7: A `start` request after firing leaves `fire` all ones and starts no new run.
- R8: After reset, the chain returns to quiet. A new start then gives the same latency as the first run.
- R9: The same cell logic works for every chain length N of 2 or more. Cells exchange only their phases with their immediate neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all cells |
| rstN | input | 1 | Asynchronous active-low reset; every cell goes quiet |
| start | input | 1 | Start request, seen only by the leftmost cell through its left border |
| fire | output | N | One bit per cell; high when that cell is in its firing phase |

## Verification
The bench runs chain lengths 2 through 32 side by side, so an off-by-one in how the wave reflects at either end shows up as one length firing a cycle early or late, or as the firing order across lengths slipping. A cell whose countdown is not aligned would raise part of a chain's `fire` vector a cycle before the rest, and the monitor reports that as a partial fire. The bench also sends a second start pulse during a run and holds `start` high for several cycles. A leftmost cell that re-armed on these would move its firing cycle or make a chain fire twice. Start pulses after firing, and a reset followed by a fresh run, expose a terminal state that is not sticky or state that leaks across a reset.

// File: rtl/fire_chain_pkg.sv
package fire_chain_pkg;

  // Phase of one cell; the two EDGE values only appear on the border links.
  typedef enum logic [2:0] {
    PH_QUIET   = 3'd0,
    PH_OUT     = 3'd1,  // outbound wave passed, counting up
    PH_BACK    = 3'd2,  // reflected wave passed, holding count
    PH_ARMED   = 3'd3,  // second wave passed, counting down by two
    PH_FIRED   = 3'd4,
    PH_EDGE    = 3'd5,
    PH_EDGE_GO = 3'd6
  } phase_t;

  // Strobes from a cell's control to its counter.
  typedef struct packed {
    logic clear;
    logic inc;
    logic dec2;
  } cntCmd_t;

  typedef struct packed {
    phase_t  nxt;
    cntCmd_t cmd;
  } step_t;

  function automatic logic isBorder(input phase_t p);
    return (p == PH_EDGE) || (p == PH_EDGE_GO);
  endfunction

  // Local rule shared by every cell of the chain.
  function automatic step_t cellRule(input phase_t leftPh,
                                     input phase_t selfPh,
                                     input phase_t rightPh,
                                     input logic   cntZero);
    step_t s;
    s.nxt = selfPh;
    s.cmd = '0;
    case (selfPh)
      PH_QUIET: begin
        if (leftPh == PH_EDGE_GO || leftPh == PH_OUT) begin
          s.nxt       = (rightPh == PH_EDGE) ? PH_BACK : PH_OUT;
          s.cmd.clear = 1'b1;
        end
      end
      PH_OUT: begin
        s.cmd.inc = 1'b1;
        if (rightPh == PH_BACK) s.nxt = isBorder(leftPh) ? PH_ARMED : PH_BACK;
      end
      PH_BACK: begin
        if (leftPh == PH_ARMED) s.nxt = PH_ARMED;
      end
      PH_ARMED: begin
        if (cntZero) s.nxt = PH_FIRED;
        else         s.cmd.dec2 = 1'b1;
      end
      PH_FIRED: s.nxt = PH_FIRED;
      default:  s.nxt = PH_QUIET;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fire_cell_ctrl.sv
module fire_cell_ctrl
  import fire_chain_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  phase_t  leftPh,
  input  phase_t  rightPh,
  input  logic    cntZero,
  output phase_t  selfPh,
  output cntCmd_t cmd
);

  step_t step;

  always_comb step = cellRule(leftPh, selfPh, rightPh, cntZero);
  assign cmd = step.cmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selfPh <= PH_QUIET;
    else       selfPh <= step.nxt;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (selfPh == PH_QUIET && leftPh != PH_OUT && leftPh != PH_EDGE_GO) |=> (selfPh == PH_QUIET)); // R2
  AST_FIRED_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (selfPh == PH_FIRED) |=> (selfPh == PH_FIRED)); // R5
  AST_FIRE_AFTER_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfPh == PH_FIRED) |-> ($past(selfPh) == PH_ARMED)); // R4

endmodule

// File: rtl/fire_cell_count.sv
module fire_cell_count
  import fire_chain_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    cntZero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (cmd.clear) cnt <= '0;
    else if (cmd.inc)   cnt <= cnt + 1'b1;
    else if (cmd.dec2)  cnt <= cnt - CNT_W'(2);
  end

  assign cntZero = (cnt == '0);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cmd) <= 1); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec2 |-> (cnt >= CNT_W'(2))); // R4
  AST_EVEN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec2 |-> !cnt[0]); // R4

endmodule

// File: rtl/fire_cell.sv
module fire_cell
  import fire_chain_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  phase_t leftPh,
  input  phase_t rightPh,
  output phase_t selfPh,
  output logic   fire
);

  cntCmd_t cmd;
  logic    cntZero;

  fire_cell_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .leftPh  (leftPh),
    .rightPh (rightPh),
    .cntZero (cntZero),
    .selfPh  (selfPh),
    .cmd     (cmd)
  );

  fire_cell_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .cntZero (cntZero)
  );

  assign fire = (selfPh == PH_FIRED);

endmodule

// File: rtl/fire_chain.sv
module fire_chain
  import fire_chain_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic [N-1:0] fire
);

  // Count reaches at most 2N-2.
  localparam int CNT_W = $clog2(2 * N);

  // linkPh[0] and linkPh[N+1] are the borders, linkPh[i+1] is cell i.
  phase_t linkPh [N+2];

  assign linkPh[0]   = start ? PH_EDGE_GO : PH_EDGE;
  assign linkPh[N+1] = PH_EDGE;

  for (genvar i = 0; i < N; i++) begin : g_cell
    fire_cell #(.CNT_W(CNT_W)) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .leftPh  (linkPh[i]),
      .rightPh (linkPh[i+2]),
      .selfPh  (linkPh[i+1]),
      .fire    (fire[i])
    );
  end

  AST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (fire == '0) || (fire == '1)); // R3
  AST_FIRE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fire == '1) |=> (fire == '1)); // R5
  AST_QUIET_NO_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (linkPh[1] == PH_QUIET) |-> (fire == '0)); // R2

endmodule

// File: tb/fire_chain_tb.sv
`timescale 1ns/1ps
module fire_chain_tb;

  localparam int MIN_N = 2;
  localparam int MAX_N = 32;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [MAX_N:0] allOnes;
  logic [MAX_N:0] anyOnes;
  assign allOnes[MIN_N-1:0] = '0;
  assign anyOnes[MIN_N-1:0] = '0;

  for (genvar gn = MIN_N; gn <= MAX_N; gn++) begin : g_len
    logic [gn-1:0] f;
    fire_chain #(.N(gn)) u_dut (
      .clk   (clk),
      .rstN  (rstN),
      .start (start),
      .fire  (f)
    );
    assign allOnes[gn] = &f;
    assign anyOnes[gn] = |f;
  end

  typedef struct {
    int     len;
    longint due;
    longint base;
  } exp_t;

  exp_t   expQ[$];
  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  logic [MAX_N:0] prevAll = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard as chains fire.
  always @(negedge clk) begin
    if (rstN) begin
      for (int n = MIN_N; n <= MAX_N; n++) begin
        if (anyOnes[n] && !allOnes[n])
          check(1'b0, "R3", $sformatf("partial fire, len %0d", n), 1, 0);
        if (allOnes[n] && !prevAll[n]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2", $sformatf("unexpected fire, len %0d", n), 1, 0);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            check(e.len == n, "R9", "firing order by length", n, e.len);
            check(cyc == e.due, "R4", $sformatf("fire cycle, len %0d", n), cyc, e.due);
            check((cyc - e.base) <= 3 * n, "R4", $sformatf("latency bound, len %0d", n),
                  cyc - e.base, 3 * n);
          end
        end
        if (prevAll[n] && !allOnes[n])
          check(1'b0, "R5", $sformatf("fire dropped, len %0d", n), 0, 1);
      end
      prevAll = allOnes;
    end else begin
      prevAll = '0;
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(anyOnes == '0, "R1", "fire during reset", longint'(anyOnes), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(anyOnes == '0, "R1", "fire after reset release", longint'(anyOnes), 0);
  endtask

  // Driver: raise start, push one expected fire per length.
  task automatic raiseStart();
    longint base;
    @(negedge clk);
    start = 1'b1;
    base = cyc + 1;
    for (int n = MIN_N; n <= MAX_N; n++)
      expQ.push_back('{len: n, due: base + 3 * n - 2, base: base});
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitRun(input string req);
    repeat (3 * MAX_N + 8) @(negedge clk);
    check(expQ.size() == 0, req, "expected fires still pending", expQ.size(), 0);
    check(allOnes[MAX_N:MIN_N] == '1, req, "all chains firing", longint'(allOnes[MAX_N:MIN_N]),
          longint'({(MAX_N - MIN_N + 1){1'b1}}));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", WATCHDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R1, R2: reset and long idle
    doReset();
    repeat (150) @(negedge clk);
    check(anyOnes == '0, "R2", "fire without start", longint'(anyOnes), 0);

    // R4, R9: single pulse run
    raiseStart();
    @(negedge clk);
    start = 1'b0;
    waitRun("R4");

    // R7: start after firing
    pulseStart();
    repeat (20) @(negedge clk);
    check(allOnes[MAX_N:MIN_N] == '1, "R7", "fire held after late start",
          longint'(allOnes[MAX_N:MIN_N]), longint'({(MAX_N - MIN_N + 1){1'b1}}));
    check(expQ.size() == 0, "R7", "no extra run", expQ.size(), 0);

    // R8, R6: fresh run with extra pulses mid-run
    doReset();
    check(allOnes == '0, "R8", "chains quiet after reset", longint'(allOnes), 0);
    raiseStart();
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    waitRun("R6");

    // R6: start held high for several cycles
    doReset();
    raiseStart();
    repeat (5) @(negedge clk);
    start = 1'b0;
    waitRun("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule